// File: doc/BRIEF.md
# Address-Valid Multiplexed Read Sequencer

This block runs single read transfers to external devices that latch their address on a one-cycle address-valid strobe, such as burst-capable NOR flash. A host presents a chip-select index and an address. The sequencer then drives the bus. It pulls the chosen active-low select and the strobe low together, puts the address on the lines, and opens output enable at a programmed point. After a two-cycle data phase it returns the sampled 16-bit word on a one-cycle response pulse.

Each of the six selects has its own 32-bit timing word, written and read through a small configuration port. The word sets three values: a read-hold count measured from select assertion, a strobe-to-output-enable gap, and an option that keeps the address on the lines for one more cycle after the strobe. Output enable opens at the latest of the points these values define. The timing is captured when a request is accepted, so changing a register affects only later transfers.

Top module: `adv_rd_seq`

## Requirements
- R1: While reset is held and right after it is released, every select line, the strobe and output enable are high, `req_ready` is 1, `rsp_valid` is 0, and every timing register reads 0.
- R2: The timing word for select n sits at byte offset 0x28 + 4*n. Bits [27:24] are the read-hold count, bits [17:16] are the strobe-to-OE gap and bit 5 is the address-hold enable. All other bits read back 0, and a write to any other offset changes no register.
- R3: A request accepted on a clock edge makes, in the next cycle (cycle 0), only the selected line `bus_cs_n[req_cs]` go low. `bus_adv_n` is low in that cycle only, and `bus_addr` carries the request address.
- R4: If address hold is set, `bus_addr` also carries the address in cycle 1. In every other cycle `bus_addr` is 0.
- R5: `bus_oe_n` first goes low in cycle max(hold, gap, 2 if address hold is set else 0).
- R6: `bus_oe_n` stays low for exactly two cycles. `bus_data_in` is sampled at the end of the second cycle, and both the select and `bus_oe_n` go high in the cycle after it.
- R7: `rsp_valid` is high for one cycle, the cycle in which the select has just gone high, and `rsp_data` then holds the sampled word.
- R8: `req_ready` is 0 from cycle 0 until the select goes high. It is 1 in that first idle cycle, so a following transfer starts its select no earlier than one full idle cycle later.
- R9: A request whose index is 6 or 7 is dropped. No select moves, `req_ready` stays 1 and no response follows.
- R10: The timing used by a transfer is the one in the register when the request was accepted. A write to that register during the transfer does not change it, but it does take effect for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset (write and read) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Read request |
| req_cs | input | 3 | Chip-select index of the request |
| req_addr | input | 9 | Request address |
| req_ready | output | 1 | Sequencer idle and able to accept |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 16 | Sampled read data |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_adv_n | output | 1 | Active-low address-valid strobe |
| bus_addr | output | 9 | Address lines |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_data_in | input | 16 | Data from the device |

## Verification
Every output is measured as a cycle count from cycle 0, the first cycle after the accepting edge. The strobe and address are due at cycle 0, with the address also at cycle 1 when hold is set. Output enable is due at t = max(hold, gap, hold-option floor) and lasts through t+1. Select release, the response pulse and `req_ready` are all due at t+2. The bench drives inputs and samples outputs on the falling edge, one sample per cycle of the transfer, and compares each sample with the value that its own count predicts for that cycle. During the first enable cycle it drives the inverse of the expected word, so a sample taken one cycle early shows up as a data mismatch.

// File: rtl/adv_rd_pkg.sv
package adv_rd_pkg;

    // field geometry of a per-select timing word
    localparam int HOLD_W    = 4;
    localparam int HOLD_LSB  = 24;
    localparam int GAP_W     = 2;
    localparam int GAP_LSB   = 16;
    localparam int AHOLD_BIT = 5;
    localparam int CFG_DW    = 32;

    // count width: largest enable point plus one for the data phase
    localparam int OE_W = HOLD_W + 1;

    // floor on the enable point when the address hold cycle is used
    localparam int AHOLD_FLOOR = 2;

    localparam logic [CFG_DW-1:0] CFG_MASK =
        ((CFG_DW'(1) << HOLD_W) - CFG_DW'(1)) << HOLD_LSB |
        ((CFG_DW'(1) << GAP_W)  - CFG_DW'(1)) << GAP_LSB  |
        (CFG_DW'(1) << AHOLD_BIT);

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [GAP_W-1:0]  gap;
        logic              ahold;
    } rd_timing_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/adv_rd_cfg.sv
module adv_rd_cfg
    import adv_rd_pkg::*;
#(
    parameter int NUM_CS   = 6,
    parameter int CFG_AW   = 8,
    parameter int CFG_BASE = 'h28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0]     cfg_wdata,
    output logic [CFG_DW-1:0]     cfg_rdata,
    output rd_timing_t            tim [NUM_CS]
);

    logic [CFG_DW-1:0] word_q [NUM_CS];
    logic [CFG_DW-1:0] word_d [NUM_CS];
    logic [NUM_CS-1:0] hit;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_reg
        localparam int unsigned OFS = CFG_BASE + 4 * i;

        assign hit[i] = (cfg_addr == OFS[CFG_AW-1:0]);

        always_comb begin
            word_d[i] = word_q[i];
            if (cfg_wr && hit[i]) begin
                word_d[i] = cfg_wdata & CFG_MASK;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else begin
                word_q[i] <= word_d[i];
            end
        end

        assign tim[i].hold  = word_q[i][HOLD_LSB +: HOLD_W];
        assign tim[i].gap   = word_q[i][GAP_LSB +: GAP_W];
        assign tim[i].ahold = word_q[i][AHOLD_BIT];
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (hit[i]) begin
                cfg_rdata = word_q[i];
            end
        end
    end

endmodule

// File: rtl/adv_rd_oe_calc.sv
module adv_rd_oe_calc
    import adv_rd_pkg::*;
(
    input  rd_timing_t       tim,
    output logic [OE_W-1:0]  oe_at
);

    logic [OE_W-1:0] from_hold;
    logic [OE_W-1:0] from_gap;
    logic [OE_W-1:0] from_ahold;
    logic [OE_W-1:0] max_hg;

    always_comb begin
        from_hold  = OE_W'(tim.hold);
        from_gap   = OE_W'(tim.gap);
        from_ahold = tim.ahold ? OE_W'(AHOLD_FLOOR) : '0;
        max_hg     = (from_hold > from_gap) ? from_hold : from_gap;
        oe_at      = (max_hg > from_ahold) ? max_hg : from_ahold;
    end

endmodule

// File: rtl/adv_rd_fsm.sv
module adv_rd_fsm
    import adv_rd_pkg::*;
#(
    parameter int NUM_CS   = 6,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 16,
    parameter int CS_IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CS_IDX_W-1:0]  req_cs,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [OE_W-1:0]      req_oe_at,
    input  logic                 req_ahold,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_data,
    output logic [NUM_CS-1:0]    bus_cs_n,
    output logic                 bus_adv_n,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_oe_n,
    input  logic [DATA_W-1:0]    bus_data_in
);

    localparam logic [CS_IDX_W:0] CS_LIMIT = (CS_IDX_W + 1)'(NUM_CS);

    typedef struct packed {
        seq_state_e          st;
        logic [OE_W-1:0]     cnt;
        logic [OE_W-1:0]     oe_at;
        logic                ahold;
        logic [NUM_CS-1:0]   sel;
        logic [ADDR_W-1:0]   addr;
        logic                rsp_v;
        logic [DATA_W-1:0]   rsp_d;
    } seq_t;

    seq_t s_q;
    seq_t s_d;

    logic                idx_ok;
    logic [NUM_CS-1:0]   sel_dec;
    logic                active;
    logic                last_cycle;

    always_comb begin
        idx_ok  = ({1'b0, req_cs} < CS_LIMIT);
        sel_dec = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            sel_dec[i] = (req_cs == CS_IDX_W'(i));
        end
    end

    assign active     = (s_q.st == S_RUN);
    assign last_cycle = active && (s_q.cnt == s_q.oe_at + OE_W'(1));

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (req_valid && idx_ok) begin
                    s_d.st    = S_RUN;
                    s_d.cnt   = '0;
                    s_d.oe_at = req_oe_at;
                    s_d.ahold = req_ahold;
                    s_d.sel   = sel_dec;
                    s_d.addr  = req_addr;
                end
            end
            S_RUN: begin
                if (last_cycle) begin
                    s_d.st    = S_IDLE;
                    s_d.rsp_v = 1'b1;
                    s_d.rsp_d = bus_data_in;
                end else begin
                    s_d.cnt = s_q.cnt + OE_W'(1);
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        req_ready = !active;
        rsp_valid = s_q.rsp_v;
        rsp_data  = s_q.rsp_d;
        bus_cs_n  = active ? ~s_q.sel : '1;
        bus_adv_n = !(active && (s_q.cnt == '0));
        bus_oe_n  = !(active && (s_q.cnt >= s_q.oe_at));
        bus_addr  = '0;
        if (active && ((s_q.cnt == '0) || (s_q.ahold && (s_q.cnt == OE_W'(1))))) begin
            bus_addr = s_q.addr;
        end
    end

endmodule

// File: rtl/adv_rd_seq.sv
module adv_rd_seq
    import adv_rd_pkg::*;
#(
    parameter int NUM_CS   = 6,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 16,
    parameter int CFG_AW   = 8,
    parameter int CFG_BASE = 'h28
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    input  logic                          req_valid,
    input  logic [$clog2(NUM_CS)-1:0]     req_cs,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          req_ready,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_data,
    output logic [NUM_CS-1:0]             bus_cs_n,
    output logic                          bus_adv_n,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic                          bus_oe_n,
    input  logic [DATA_W-1:0]             bus_data_in
);

    localparam int CS_IDX_W = $clog2(NUM_CS);

    rd_timing_t      tim [NUM_CS];
    rd_timing_t      sel_tim;
    logic [OE_W-1:0] sel_oe_at;

    adv_rd_cfg #(
        .NUM_CS   (NUM_CS),
        .CFG_AW   (CFG_AW),
        .CFG_BASE (CFG_BASE)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tim       (tim)
    );

    always_comb begin
        sel_tim = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (req_cs == CS_IDX_W'(i)) begin
                sel_tim = tim[i];
            end
        end
    end

    adv_rd_oe_calc u_calc (
        .tim   (sel_tim),
        .oe_at (sel_oe_at)
    );

    adv_rd_fsm #(
        .NUM_CS   (NUM_CS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CS_IDX_W (CS_IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cs      (req_cs),
        .req_addr    (req_addr),
        .req_oe_at   (sel_oe_at),
        .req_ahold   (sel_tim.ahold),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .bus_cs_n    (bus_cs_n),
        .bus_adv_n   (bus_adv_n),
        .bus_addr    (bus_addr),
        .bus_oe_n    (bus_oe_n),
        .bus_data_in (bus_data_in)
    );

endmodule

// File: rtl/adv_rd_seq_chk.sv
module adv_rd_seq_chk #(
    parameter int NUM_CS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] bus_cs_n,
    input logic              bus_adv_n,
    input logic              bus_oe_n,
    input logic              req_ready,
    input logic              rsp_valid
);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));                                                  // R3

    AST_STROBE_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_adv_n |-> ($countones(~bus_cs_n) == 1));                          // R3

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_adv_n |=> bus_adv_n);                                             // R3

    AST_OE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> (~bus_cs_n != '0));                                      // R6

    AST_OE_SELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_n) |-> (&bus_cs_n));                                      // R6

    AST_RSP_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!bus_oe_n));                                       // R7

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&bus_cs_n));                                            // R8

    AST_STROBE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_adv_n) |-> $past(&bus_cs_n));                                // R8

endmodule

bind adv_rd_seq adv_rd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs_n  (bus_cs_n),
    .bus_adv_n (bus_adv_n),
    .bus_oe_n  (bus_oe_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/adv_rd_seq_bench.sv
module adv_rd_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cs = '0;
    logic [8:0]  req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [5:0]  bus_cs_n;
    logic        bus_adv_n;
    logic [8:0]  bus_addr;
    logic        bus_oe_n;
    logic [15:0] bus_data_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adv_rd_seq u_adv_rd_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_cs(req_cs), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n), .bus_addr(bus_addr),
        .bus_oe_n(bus_oe_n), .bus_data_in(bus_data_in)
    );

    // {cs[34:32], hold[31:28], gap[27:26], ahold[25], addr[24:16], data[15:0]}
    localparam logic [34:0] VEC [8] = '{
        {3'd0, 4'd0,  2'd0, 1'b0, 9'h055, 16'hA5A5},
        {3'd1, 4'd5,  2'd1, 1'b0, 9'h1F0, 16'h1234},
        {3'd2, 4'd1,  2'd3, 1'b0, 9'h0AA, 16'hBEEF},
        {3'd3, 4'd0,  2'd0, 1'b1, 9'h133, 16'h0F0F},
        {3'd4, 4'd15, 2'd3, 1'b1, 9'h1FF, 16'hC001},
        {3'd5, 4'd1,  2'd1, 1'b1, 9'h001, 16'h8000},
        {3'd2, 4'd3,  2'd2, 1'b1, 9'h100, 16'h7E7E},
        {3'd0, 4'd2,  2'd3, 1'b0, 9'h0C3, 16'h5AA5}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input int h, input int g, input int ah);
        return {4'b0, 4'(h), 6'b0, 2'(g), 10'b0, 1'(ah), 5'b0};
    endfunction

    task automatic cfg_write(input logic [7:0] ofs, input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_expect(input logic [7:0] ofs, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = ofs;
        #1;
        chk(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    // one read; mid!=0 writes mid_word to the same register during cycle 1
    task automatic do_read(input int cs, input logic [8:0] a, input logic [15:0] d,
                           input int h, input int g, input int ah,
                           input bit mid, input logic [31:0] mid_word);
        int t;
        int oe_seen;
        logic [5:0] exp_cs;
        t = (h > g) ? h : g;
        if (ah != 0 && t < 2) t = 2;
        exp_cs = ~(6'd1 << cs);
        oe_seen = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready before request", req_ready, 1);
        req_valid = 1'b1; req_cs = 3'(cs); req_addr = a; bus_data_in = ~d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k <= t + 3; k++) begin
            chk(bus_cs_n == ((k <= t + 1) ? exp_cs : 6'h3F), "R3/R6 select", bus_cs_n,
                (k <= t + 1) ? exp_cs : 6'h3F);
            chk(bus_adv_n == (k != 0), "R3 strobe", bus_adv_n, (k != 0));
            chk(bus_addr == ((k == 0 || (ah != 0 && k == 1)) ? a : 9'h0), "R4 address", bus_addr,
                (k == 0 || (ah != 0 && k == 1)) ? a : 9'h0);
            chk(bus_oe_n == !(k >= t && k <= t + 1), "R5/R6 output enable", bus_oe_n,
                !(k >= t && k <= t + 1));
            chk(req_ready == (k >= t + 2), "R8 ready", req_ready, (k >= t + 2));
            chk(rsp_valid == (k == t + 2), "R7 response pulse", rsp_valid, (k == t + 2));
            if (k == t + 2) begin
                chk(rsp_data == d, "R6/R7 data", rsp_data, d);
            end
            if (!bus_oe_n) oe_seen++;
            bus_data_in = (oe_seen == 2) ? d : ~d;
            if (mid && k == 1) begin
                cfg_wr = 1'b1; cfg_addr = 8'(8'h28 + 4 * cs); cfg_wdata = mid_word;
            end else begin
                cfg_wr = 1'b0;
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: state while reset is held and just after release
        repeat (3) @(negedge clk);
        chk(bus_cs_n == 6'h3F, "R1 select in reset", bus_cs_n, 6'h3F);
        chk(bus_oe_n && bus_adv_n, "R1 strobe/enable in reset", {bus_adv_n, bus_oe_n}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake after reset",
            {req_ready, rsp_valid}, 2'b10);
        for (int i = 0; i < 6; i++) cfg_expect(8'(8'h28 + 4 * i), 32'h0, "R1 register reset");

        // R2: field masking and unmapped offsets
        cfg_write(8'h34, 32'hFFFF_FFFF);
        cfg_expect(8'h34, 32'h0F03_0020, "R2 defined bits only");
        cfg_write(8'h24, 32'hFFFF_FFFF);
        cfg_write(8'h40, 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++)
            cfg_expect(8'(8'h28 + 4 * i), (i == 3) ? 32'h0F03_0020 : 32'h0, "R2 unmapped write ignored");
        cfg_expect(8'h40, 32'h0, "R2 unmapped read zero");

        // table of transfers: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            cfg_write(8'(8'h28 + 4 * int'(VEC[v][34:32])),
                      mk_word(int'(VEC[v][31:28]), int'(VEC[v][27:26]), int'(VEC[v][25])));
            do_read(int'(VEC[v][34:32]), VEC[v][24:16], VEC[v][15:0],
                    int'(VEC[v][31:28]), int'(VEC[v][27:26]), int'(VEC[v][25]), 1'b0, 32'h0);
        end

        // back-to-back transfers on different selects: R8
        do_read(1, 9'h011, 16'h2222, 5, 1, 0, 1'b0, 32'h0);
        do_read(2, 9'h022, 16'h3333, 3, 2, 1, 1'b0, 32'h0);

        // R9: out-of-range index dropped
        for (int bad = 6; bad < 8; bad++) begin
            @(negedge clk);
            req_valid = 1'b1; req_cs = 3'(bad); req_addr = 9'h1AB;
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 4; k++) begin
                chk(bus_cs_n == 6'h3F && req_ready && !rsp_valid && bus_adv_n,
                    "R9 bad index ignored", {bus_cs_n, req_ready, rsp_valid}, {6'h3F, 2'b10});
                @(negedge clk);
            end
        end

        // R10: register write during transfer does not retime it
        cfg_write(8'h2C, mk_word(8, 0, 0));
        do_read(1, 9'h0EE, 16'h4C4C, 8, 0, 0, 1'b1, mk_word(0, 0, 0));
        cfg_expect(8'h2C, 32'h0, "R10 write landed");
        do_read(1, 9'h0EF, 16'h4D4D, 0, 0, 0, 1'b0, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule